// File: doc/BRIEF.md
# Lane Execute-Directive Sequencer

This block sits between a control processor and a row of execution lanes. The control side hands it directives. Each directive names a short block of instructions, given as a start index and a length into a small per-lane instruction store, together with a 16-bit mask of the virtual processors (VPs) that must run that block. The VPs are striped across four lanes. VP `n` belongs to lane `n % 4` and uses register bank `n / 4` inside that lane. Each lane keeps only the mask bits that belong to it and queues the directive in its own small queue. It then works through its selected VPs one at a time and issues every instruction index of the block for each one, tagged with the VP's bank id.

The lanes are decoupled. One lane can stall waiting for an instruction word while another keeps issuing. When a lane reaches a store entry that has not been loaded, it holds and raises a refill request for that index. A single shared fill port writes the returned word into every lane's store at once. A done flag tells the control side that all queued work has drained.

Top module: `vt_lane_sequencer`

## Requirements
- R1: VP `n` (bit `n` of `dir_vp_mask`) is served only by lane `n % 4`, and its issued instructions carry bank id `n / 4` on that lane's `issue_bank` slice.
- R2: Lanes progress independently: a lane stalled on a missing store entry does not stop another lane from issuing, and a lane with no selected VPs issues nothing.
- R3: For each served VP a lane issues the indices `start, start+1, ...`, wrapping modulo 32, for exactly `dir_len_m1 + 1` consecutive issues (1 to 32).
- R4: Within a lane, selected VPs are served in ascending bank id, and all instructions of the block are issued for one VP before the next VP starts.
- R5: Each lane queues up to 4 directives. `dir_ready` is low whenever any lane queue is full. A directive is taken on a cycle where `dir_valid` and `dir_ready` are both high.
- R6: A lane never issues an index whose store entry is unloaded. While stalled it holds `fill_req` high with `fill_req_idx` equal to the waiting index, and it resumes once that index is filled.
- R7: A write on the fill port loads the word into every lane's store. `issue_instr` shows the word last written at the issued index.
- R8: `done` is high exactly when every lane queue is empty and no lane is issuing or stalled.
- R9: After reset, `dir_ready` and `done` are high, no `issue_valid` or `fill_req` bit is set, and every store entry is unloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the caller releases it in step with clk |
| dir_valid | input | 1 | Directive offered |
| dir_ready | output | 1 | Directive can be taken (no lane queue full) |
| dir_start | input | 5 | First instruction index of the block |
| dir_len_m1 | input | 5 | Block length minus one |
| dir_vp_mask | input | 16 | One bit per VP that must run the block |
| fill_valid | input | 1 | Store write strobe, broadcast to all lanes |
| fill_index | input | 5 | Store index to write |
| fill_data | input | 16 | Instruction word to write |
| fill_req | output | 4 | Per lane: stalled on an unloaded entry |
| fill_req_idx | output | 20 | Per lane, 5 bits each: index being waited for |
| issue_valid | output | 4 | Per lane: an instruction is issued this cycle |
| issue_idx | output | 20 | Per lane, 5 bits each: issued store index |
| issue_bank | output | 8 | Per lane, 2 bits each: register bank id of the VP |
| issue_instr | output | 64 | Per lane, 16 bits each: issued instruction word |
| done | output | 1 | All queues empty and all lanes idle |

## Verification
The assertions assume that the caller never pushes into a full queue. This means `dir_valid` only counts as taken when `dir_ready` is high. They also assume that a fill to the index a lane waits on eventually arrives, and that reset is released in step with the clock. The bench honours these assumptions. Its driver holds a directive until it sees `dir_ready`, and its fill responder answers every raised `fill_req` after a short random delay. It keeps the responder switched off only during a bounded directed window, which it uses to fill a queue and hold a stall on purpose.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic {
    LS_IDLE = 1'b0,
    LS_RUN  = 1'b1
  } lane_state_e;

endpackage

// File: rtl/vts_dir_fifo.sv
module vts_dir_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = ptr_inc(wr_q);
    if (pop)  rd_d = ptr_inc(rd_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R5: a queue never takes an entry past its depth
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CNT_W'(DEPTH)));

  // R5: a queue is never popped while empty
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/vts_instr_store.sv
module vts_instr_store #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0]     word_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx] <= wr_data;
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_data  = word_q[rd_idx];

endmodule

// File: rtl/vts_lane.sv
module vts_lane
  import vts_pkg::*;
#(
  parameter int VPL         = 4,
  parameter int STORE_DEPTH = 32,
  parameter int QDEPTH      = 4,
  parameter int INSTR_W     = 16,
  localparam int IDX_W  = $clog2(STORE_DEPTH),
  localparam int BANK_W = (VPL > 1) ? $clog2(VPL) : 1,
  localparam int ENT_W  = 2 * IDX_W + VPL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [IDX_W-1:0]   push_start,
  input  logic [IDX_W-1:0]   push_len_m1,
  input  logic [VPL-1:0]     push_mask,
  input  logic               fill_we,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [INSTR_W-1:0] fill_data,
  output logic               q_full,
  output logic               q_empty,
  output logic               busy,
  output logic               issue_valid,
  output logic [IDX_W-1:0]   issue_idx,
  output logic [BANK_W-1:0]  issue_bank,
  output logic [INSTR_W-1:0] issue_instr,
  output logic               fill_req,
  output logic [IDX_W-1:0]   fill_req_idx
);

  lane_state_e      state_q, state_d;
  logic [IDX_W-1:0] start_q, start_d;
  logic [IDX_W-1:0] lenm1_q, lenm1_d;
  logic [IDX_W-1:0] off_q, off_d;
  logic [VPL-1:0]   pend_q, pend_d;
  logic [BANK_W-1:0] vp_q, vp_d;

  logic [ENT_W-1:0] q_wdata, q_rdata;
  logic             q_pop;
  logic [IDX_W-1:0] head_start, head_lenm1;
  logic [VPL-1:0]   head_mask;

  logic [IDX_W-1:0] cur_idx;
  logic             hit;
  logic             last_off;
  logic [VPL-1:0]   pend_left;

  function automatic logic [BANK_W-1:0] first_set(input logic [VPL-1:0] m);
    first_set = '0;
    for (int i = VPL - 1; i >= 0; i--) begin
      if (m[i]) first_set = BANK_W'(i);
    end
  endfunction

  assign q_wdata = {push_start, push_len_m1, push_mask};
  assign {head_start, head_lenm1, head_mask} = q_rdata;

  vts_dir_fifo #(
    .W     (ENT_W),
    .DEPTH (QDEPTH)
  ) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (q_wdata),
    .pop   (q_pop),
    .rdata (q_rdata),
    .empty (q_empty),
    .full  (q_full)
  );

  vts_instr_store #(
    .DEPTH (STORE_DEPTH),
    .W     (INSTR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fill_we),
    .wr_idx   (fill_idx),
    .wr_data  (fill_data),
    .rd_idx   (cur_idx),
    .rd_valid (hit),
    .rd_data  (issue_instr)
  );

  assign cur_idx   = start_q + off_q;
  assign last_off  = (off_q == lenm1_q);
  assign pend_left = pend_q & ~(VPL'(1) << vp_q);

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    lenm1_d = lenm1_q;
    off_d   = off_q;
    pend_d  = pend_q;
    vp_d    = vp_q;
    q_pop   = 1'b0;
    case (state_q)
      LS_IDLE: begin
        if (!q_empty) begin
          q_pop   = 1'b1;
          start_d = head_start;
          lenm1_d = head_lenm1;
          pend_d  = head_mask;
          vp_d    = first_set(head_mask);
          off_d   = '0;
          state_d = LS_RUN;
        end
      end
      LS_RUN: begin
        if (hit) begin
          if (last_off) begin
            pend_d = pend_left;
            off_d  = '0;
            if (pend_left == '0) state_d = LS_IDLE;
            else                 vp_d    = first_set(pend_left);
          end else begin
            off_d = off_q + 1'b1;
          end
        end
      end
      default: state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
      start_q <= '0;
      lenm1_q <= '0;
      off_q   <= '0;
      pend_q  <= '0;
      vp_q    <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      lenm1_q <= lenm1_d;
      off_q   <= off_d;
      pend_q  <= pend_d;
      vp_q    <= vp_d;
    end
  end

  assign busy         = (state_q == LS_RUN);
  assign issue_valid  = busy && hit;
  assign issue_idx    = cur_idx;
  assign issue_bank   = vp_q;
  assign fill_req     = busy && !hit;
  assign fill_req_idx = cur_idx;

  // R3: inside one VP's block, the next index follows the issued one
  a_r3_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !last_off) |=> (cur_idx == $past(cur_idx) + IDX_W'(1)));

  // R4: a lane only moves on to higher-numbered VPs within a directive
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (vp_q != $past(vp_q))) |-> (vp_q > $past(vp_q)));

  // R6: a stall holds on the same index until that index is filled
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !(fill_we && (fill_idx == cur_idx))) |=>
      (fill_req && (cur_idx == $past(cur_idx))));

endmodule

// File: rtl/vt_lane_sequencer.sv
module vt_lane_sequencer #(
  parameter int NUM_LANES   = 4,
  parameter int NUM_VPS     = 16,
  parameter int STORE_DEPTH = 32,
  parameter int QUEUE_DEPTH = 4,
  parameter int INSTR_W     = 16,
  localparam int IDX_W  = $clog2(STORE_DEPTH),
  localparam int VPL    = NUM_VPS / NUM_LANES,
  localparam int BANK_W = (VPL > 1) ? $clog2(VPL) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dir_valid,
  output logic                          dir_ready,
  input  logic [IDX_W-1:0]              dir_start,
  input  logic [IDX_W-1:0]              dir_len_m1,
  input  logic [NUM_VPS-1:0]            dir_vp_mask,
  input  logic                          fill_valid,
  input  logic [IDX_W-1:0]              fill_index,
  input  logic [INSTR_W-1:0]            fill_data,
  output logic [NUM_LANES-1:0]          fill_req,
  output logic [NUM_LANES*IDX_W-1:0]    fill_req_idx,
  output logic [NUM_LANES-1:0]          issue_valid,
  output logic [NUM_LANES*IDX_W-1:0]    issue_idx,
  output logic [NUM_LANES*BANK_W-1:0]   issue_bank,
  output logic [NUM_LANES*INSTR_W-1:0]  issue_instr,
  output logic                          done
);

  logic [NUM_LANES-1:0] lane_full, lane_empty, lane_busy, lane_push;
  logic                 accept;

  assign dir_ready = ~|lane_full;
  assign accept    = dir_valid && dir_ready;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [VPL-1:0] sub_mask;

    for (genvar s = 0; s < VPL; s++) begin : g_slot
      assign sub_mask[s] = dir_vp_mask[s * NUM_LANES + l];
    end

    assign lane_push[l] = accept && (|sub_mask);

    vts_lane #(
      .VPL         (VPL),
      .STORE_DEPTH (STORE_DEPTH),
      .QDEPTH      (QUEUE_DEPTH),
      .INSTR_W     (INSTR_W)
    ) u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .push         (lane_push[l]),
      .push_start   (dir_start),
      .push_len_m1  (dir_len_m1),
      .push_mask    (sub_mask),
      .fill_we      (fill_valid),
      .fill_idx     (fill_index),
      .fill_data    (fill_data),
      .q_full       (lane_full[l]),
      .q_empty      (lane_empty[l]),
      .busy         (lane_busy[l]),
      .issue_valid  (issue_valid[l]),
      .issue_idx    (issue_idx[l*IDX_W +: IDX_W]),
      .issue_bank   (issue_bank[l*BANK_W +: BANK_W]),
      .issue_instr  (issue_instr[l*INSTR_W +: INSTR_W]),
      .fill_req     (fill_req[l]),
      .fill_req_idx (fill_req_idx[l*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    done = (&lane_empty) && !(|lane_busy);
  end

  // R8: while done is high no lane issues or waits for a refill
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((issue_valid == '0) && (fill_req == '0)));

  // R5: a taken directive with work clears done on the next cycle
  a_r5_take_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (dir_vp_mask != '0)) |=> !done);

endmodule

// File: tb/vt_lane_sequencer_bench.sv
module vt_lane_sequencer_bench;

  localparam int NL = 4;
  localparam int NV = 16;
  localparam int IW = 5;
  localparam int BW = 2;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dir_valid = 1'b0;
  logic            dir_ready;
  logic [IW-1:0]   dir_start = '0;
  logic [IW-1:0]   dir_len_m1 = '0;
  logic [NV-1:0]   dir_vp_mask = '0;
  logic            fill_valid = 1'b0;
  logic [IW-1:0]   fill_index = '0;
  logic [DW-1:0]   fill_data = '0;
  logic [NL-1:0]   fill_req;
  logic [NL*IW-1:0] fill_req_idx;
  logic [NL-1:0]   issue_valid;
  logic [NL*IW-1:0] issue_idx;
  logic [NL*BW-1:0] issue_bank;
  logic [NL*DW-1:0] issue_instr;
  logic            done;

  always #2 clk = ~clk;

  vt_lane_sequencer u_vt_lane_sequencer (
    .clk(clk), .rst_n(rst_n),
    .dir_valid(dir_valid), .dir_ready(dir_ready),
    .dir_start(dir_start), .dir_len_m1(dir_len_m1), .dir_vp_mask(dir_vp_mask),
    .fill_valid(fill_valid), .fill_index(fill_index), .fill_data(fill_data),
    .fill_req(fill_req), .fill_req_idx(fill_req_idx),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .issue_bank(issue_bank), .issue_instr(issue_instr),
    .done(done)
  );

  int unsigned expq [NL][$];
  logic [31:0] filled = '0;
  int n_checks = 0, n_fail = 0;
  int mon_checks = 0, mon_fail = 0;
  int man_cnt = 0, served = 0;
  logic [IW-1:0] man_idx = '0;
  bit resp_en = 1'b0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] word_of(input logic [IW-1:0] i);
    return 16'hC35A ^ ({11'd0, i} * 16'h0907);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fill responder: manual fills first, then answers lane refill requests
  int wait_cnt = 0;
  int wait_thr = 1;
  always begin
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    if (served < man_cnt) begin
      fill_valid = 1'b1;
      fill_index = man_idx;
      fill_data  = word_of(man_idx);
      filled[man_idx] = 1'b1;
      served++;
    end else if (resp_en && (|fill_req)) begin
      if (wait_cnt >= wait_thr) begin
        for (int l = NL - 1; l >= 0; l--) begin
          if (fill_req[l]) fill_index = fill_req_idx[l*IW +: IW];
        end
        fill_valid = 1'b1;
        fill_data  = word_of(fill_index);
        filled[fill_index] = 1'b1;
        wait_cnt = 0;
        wait_thr = int'($urandom % 4);
      end else begin
        wait_cnt++;
      end
    end
  end

  // scoreboard monitor, samples away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int l = 0; l < NL; l++) begin
        if (issue_valid[l]) begin
          int unsigned e;
          logic [IW-1:0] ai;
          logic [BW-1:0] ab;
          ai = issue_idx[l*IW +: IW];
          ab = issue_bank[l*BW +: BW];
          mon_checks++;
          if (expq[l].size() == 0) begin
            mon_fail++;
            $display("FAIL R2: lane %0d issued idx %0d with no work expected (expected 0 issues)", l, ai);
          end else begin
            e = expq[l].pop_front();
            if (ai != IW'(e & 32'h1F)) begin
              mon_fail++;
              $display("FAIL R3: lane %0d idx actual %0d expected %0d", l, ai, e & 32'h1F);
            end
            if (ab != BW'(e >> 8)) begin
              mon_fail++;
              $display("FAIL R1/R4: lane %0d bank actual %0d expected %0d", l, ab, e >> 8);
            end
          end
          if (issue_instr[l*DW +: DW] != word_of(ai)) begin
            mon_fail++;
            $display("FAIL R7: lane %0d instr actual %0h expected %0h", l,
                     issue_instr[l*DW +: DW], word_of(ai));
          end
          if (!filled[ai]) begin
            mon_fail++;
            $display("FAIL R6: lane %0d issued unloaded idx %0d (loaded actual 0 expected 1)", l, ai);
          end
        end
        if (fill_req[l]) begin
          mon_checks++;
          if (issue_valid[l]) begin
            mon_fail++;
            $display("FAIL R6: lane %0d issue_valid actual 1 expected 0 during stall", l);
          end
          if (expq[l].size() == 0) begin
            mon_fail++;
            $display("FAIL R6: lane %0d refill request actual 1 expected 0", l);
          end else if (fill_req_idx[l*IW +: IW] != IW'(expq[l][0] & 32'h1F)) begin
            mon_fail++;
            $display("FAIL R6: lane %0d refill idx actual %0d expected %0d", l,
                     fill_req_idx[l*IW +: IW], expq[l][0] & 32'h1F);
          end
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1'b1;
      $display("FAIL watchdog: cycles actual %0d expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end

  task automatic send(input logic [IW-1:0] st, input logic [IW-1:0] lm1, input logic [NV-1:0] m);
    @(posedge clk);
    #1;
    dir_valid   = 1'b1;
    dir_start   = st;
    dir_len_m1  = lm1;
    dir_vp_mask = m;
    while (!dir_ready) begin
      @(posedge clk);
      #1;
    end
    // R1/R3/R4: build the expected per-lane issue stream
    for (int b = 0; b < NV / NL; b++) begin
      for (int l = 0; l < NL; l++) begin
        if (m[b * NL + l]) begin
          for (int k = 0; k <= int'(lm1); k++) begin
            expq[l].push_back(((int'(st) + k) % 32) | (b << 8));
          end
        end
      end
    end
    @(posedge clk);
    #1;
    dir_valid = 1'b0;
  endtask

  task automatic manual_fill(input logic [IW-1:0] i);
    man_idx = i;
    man_cnt++;
    while (served < man_cnt) @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_done();
    do begin
      @(posedge clk);
      #1;
    end while (!done);
    for (int l = 0; l < NL; l++) begin
      chk(expq[l].size() == 0, "R8 pending work at done", expq[l].size(), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R9: reset state
    chk(dir_ready == 1'b1, "R9 dir_ready", dir_ready, 1);
    chk(done == 1'b1, "R9 done", done, 1);
    chk(issue_valid == '0, "R9 issue_valid", issue_valid, 0);
    chk(fill_req == '0, "R9 fill_req", fill_req, 0);

    // R6: empty store, VP0 stalls on index 3
    send(5'd3, 5'd1, 16'h0001);
    chk(done == 1'b0, "R8 done after take", done, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(fill_req[0] == 1'b1, "R6 stall req", fill_req[0], 1);
    chk(fill_req_idx[4:0] == 5'd3, "R6 stall idx", fill_req_idx[4:0], 3);
    chk(issue_valid[0] == 1'b0, "R6 no issue", issue_valid[0], 0);

    // R2: lane 1 runs while lane 0 stays stalled
    manual_fill(5'd20);
    send(5'd20, 5'd0, 16'h0002);
    repeat (4) @(posedge clk);
    #1;
    chk(expq[1].size() == 0, "R2 lane1 progressed", expq[1].size(), 0);
    chk(fill_req[0] == 1'b1, "R2 lane0 still stalled", fill_req[0], 1);

    // R5: four more lane-0 directives fill its queue
    for (int i = 0; i < 4; i++) send(5'(i + 8), 5'd0, 16'h0010);
    chk(dir_ready == 1'b0, "R5 ready low when full", dir_ready, 0);
    chk(done == 1'b0, "R8 done low while busy", done, 0);
    repeat (5) @(posedge clk);
    #1;
    chk(dir_ready == 1'b0, "R5 ready held low", dir_ready, 0);

    resp_en = 1'b1;
    wait_done();
    chk(dir_ready == 1'b1, "R5 ready after drain", dir_ready, 1);

    // R3: wrap past the top of the store, all VPs
    send(5'd30, 5'd3, 16'hFFFF);
    wait_done();
    // R3: full 32-entry block on a scattered mask
    send(5'd5, 5'd31, 16'h8421);
    wait_done();
    // R2: directive selecting no VP leaves everything idle
    send(5'd0, 5'd4, 16'h0000);
    @(posedge clk);
    #1;
    chk(done == 1'b1, "R2 empty mask stays done", done, 1);
    chk(issue_valid == '0, "R2 empty mask no issue", issue_valid, 0);

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [IW-1:0] st, lm1;
      logic [NV-1:0] m;
      st  = IW'($urandom % 32);
      lm1 = ($urandom % 8 == 0) ? 5'd31 : IW'($urandom % 6);
      m   = NV'($urandom);
      if ($urandom % 5 == 0) m = NV'(16'h1) << ($urandom % 16);
      send(st, lm1, m);
      repeat ($urandom % 3) @(posedge clk);
    end
    wait_done();
    chk(dir_ready == 1'b1, "R5 ready at end", dir_ready, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks, n_fail + mon_fail);
    $finish;
  end

endmodule